// File: doc/BRIEF.md
# Sorted Eight-Entry List Merger

This block joins two lists of cluster entries into a single ascending list and keeps only the front of it. Each list holds eight entries. An entry is an 11-bit pad address and a 3-bit size. Each list arrives already sorted by ascending address, because each comes from its own extractor covering one half of the pad space. The block returns the eight entries with the smallest addresses across both lists, in ascending order. Each size stays attached to its address. Unused slots carry the all-ones address 2047 (0x7FF). That value is above every real pad, so such slots sink to the tail without any special handling.

The merge is the second half of an odd-even merge sorter: four layers of compare-exchange cells keyed on address. Each layer is followed by a register stage. A result therefore appears a fixed number of cycles after its inputs, and a new pair of lists can be accepted on every clock. Addresses are taken as absolute pad numbers: the second list already carries its upper-half offset. A single strobe marks both input lists valid together, and one strobe marks the output valid.

Top module: `sorted_list_merger`

## Requirements
- R1: While reset is asserted, and after it is released until the first result arrives, `out_valid` is low and every output slot carries address 2047.
- R2: For two ascending input lists, the output holds the eight lowest addresses of the sixteen inputs in ascending order. Slot 0 is in bits [10:0] of `out_addr`, and slot i is in bits [11*i+10 : 11*i].
- R3: The size in each output slot whose address is not 2047 equals the size presented with that address on the input. Slot i of every size bus is in bits [3*i+2 : 3*i].
- R4: Entries with address 2047 sort behind every real address. When fewer than eight real entries are presented in total, the trailing output slots carry 2047.
- R5: `out_valid` is high exactly four clocks after an input pair was sampled with `in_valid` high, and low four clocks after a low sample. Back-to-back pairs produce back-to-back results.
- R6: The merge is correct for any two ascending lists, including lists whose addresses interleave, lists where one side is entirely 2047, and lists where every real entry comes from one side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Both input lists are valid this cycle |
| a_addr | input | 88 | First list, eight 11-bit addresses, ascending |
| a_size | input | 24 | First list, eight 3-bit sizes |
| b_addr | input | 88 | Second list, eight 11-bit addresses, ascending |
| b_size | input | 24 | Second list, eight 3-bit sizes |
| out_valid | output | 1 | Merged result valid |
| out_addr | output | 88 | Eight lowest addresses, ascending |
| out_size | output | 24 | Sizes matching `out_addr` slot by slot |

## Verification
The bench builds the block with its defaults: eight entries per list, 11-bit addresses and 3-bit sizes. The network therefore has sixteen lanes in four compare-exchange layers. With these values every layer distance (8, 4, 2, 1) is exercised, including the final odd-lane layer that decides the boundary between slot 7 and slot 8. The 2047 sentinel sits exactly at the top of the address range, so the tail-sorting cases can be reached. Streaming seven list pairs back to back keeps all four register stages full at once, which exposes any mixing between neighbouring results.

// File: rtl/merge_net_pkg.sv
package merge_net_pkg;

    // Lane x is the lower end of a compare-exchange at distance k in the
    // merge half of an odd-even network over n lanes.
    function automatic bit is_low_lane(input int x, input int k, input int n);
        int first;
        first = (k == n / 2) ? 0 : k;
        if (x < first)      return 1'b0;
        if (x + k >= n)     return 1'b0;
        return ((x - first) % (2 * k)) < k;
    endfunction

    function automatic bit is_high_lane(input int x, input int k, input int n);
        if (x < k) return 1'b0;
        return is_low_lane(x - k, k, n);
    endfunction

endpackage

// File: rtl/merge_cx_cell.sv
module merge_cx_cell #(
    parameter int ADDR_W = 11,
    parameter int SIZE_W = 3,
    localparam int EW = ADDR_W + SIZE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] side_a,
    input  logic [EW-1:0] side_b,
    output logic [EW-1:0] low_out,
    output logic [EW-1:0] high_out
);

    logic swap;

    // Address is the upper field of each entry; a tie keeps side_a low.
    always_comb begin
        swap = side_a[EW-1:SIZE_W] > side_b[EW-1:SIZE_W];
        if (swap) begin
            low_out  = side_b;
            high_out = side_a;
        end else begin
            low_out  = side_a;
            high_out = side_b;
        end
    end

    AST_CX_PERMUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ((low_out == side_a) && (high_out == side_b)) ||
        ((low_out == side_b) && (high_out == side_a))); // R3

    AST_CX_TIE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (side_a[EW-1:SIZE_W] == side_b[EW-1:SIZE_W]) |-> (low_out == side_a)); // R3

endmodule

// File: rtl/merge_layer.sv
module merge_layer #(
    parameter int LANES  = 16,
    parameter int DIST   = 8,
    parameter int ADDR_W = 11,
    parameter int SIZE_W = 3,
    localparam int EW = ADDR_W + SIZE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [LANES*EW-1:0] in_lanes,
    output logic                out_vld,
    output logic [LANES*EW-1:0] out_lanes
);
    import merge_net_pkg::*;

    localparam logic [EW-1:0] EMPTY = {{ADDR_W{1'b1}}, {SIZE_W{1'b0}}};

    logic [EW-1:0] nxt [LANES];

    for (genvar x = 0; x < LANES; x++) begin : g_lane
        if (is_low_lane(x, DIST, LANES)) begin : g_cx
            merge_cx_cell #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_cx (
                .clk      (clk),
                .rst_n    (rst_n),
                .side_a   (in_lanes[x*EW +: EW]),
                .side_b   (in_lanes[(x+DIST)*EW +: EW]),
                .low_out  (nxt[x]),
                .high_out (nxt[x+DIST])
            );
        end else if (!is_high_lane(x, DIST, LANES)) begin : g_pass
            assign nxt[x] = in_lanes[x*EW +: EW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            for (int i = 0; i < LANES; i++) out_lanes[i*EW +: EW] <= EMPTY;
        end else begin
            out_vld <= in_vld;
            for (int i = 0; i < LANES; i++) out_lanes[i*EW +: EW] <= nxt[i];
        end
    end

endmodule

// File: rtl/sorted_list_merger.sv
module sorted_list_merger #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 11,
    parameter int SIZE_W  = 3,
    localparam int LANES  = 2 * ENTRIES,
    localparam int LAYERS = $clog2(ENTRIES) + 1,
    localparam int EW     = ADDR_W + SIZE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [ENTRIES*ADDR_W-1:0] a_addr,
    input  logic [ENTRIES*SIZE_W-1:0] a_size,
    input  logic [ENTRIES*ADDR_W-1:0] b_addr,
    input  logic [ENTRIES*SIZE_W-1:0] b_size,
    output logic                      out_valid,
    output logic [ENTRIES*ADDR_W-1:0] out_addr,
    output logic [ENTRIES*SIZE_W-1:0] out_size
);

    localparam logic [ADDR_W-1:0] NO_PAD = '1;

    logic [LANES*EW-1:0] stage_lanes [LAYERS+1];
    logic                stage_vld   [LAYERS+1];

    // Lanes 0..ENTRIES-1 take the first list, the rest the second.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            stage_lanes[0][i*EW +: EW] =
                {a_addr[i*ADDR_W +: ADDR_W], a_size[i*SIZE_W +: SIZE_W]};
            stage_lanes[0][(ENTRIES+i)*EW +: EW] =
                {b_addr[i*ADDR_W +: ADDR_W], b_size[i*SIZE_W +: SIZE_W]};
        end
        stage_vld[0] = in_valid;
    end

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        merge_layer #(
            .LANES  (LANES),
            .DIST   (ENTRIES >> l),
            .ADDR_W (ADDR_W),
            .SIZE_W (SIZE_W)
        ) u_layer (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_vld    (stage_vld[l]),
            .in_lanes  (stage_lanes[l]),
            .out_vld   (stage_vld[l+1]),
            .out_lanes (stage_lanes[l+1])
        );
    end

    // Only the lower half of the final stage is delivered; the upper lanes
    // have no load and are trimmed away by synthesis.
    logic [ENTRIES*EW-1:0] tail_lanes_unused;
    assign tail_lanes_unused = stage_lanes[LAYERS][LANES*EW-1 : ENTRIES*EW];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            out_addr[i*ADDR_W +: ADDR_W] = stage_lanes[LAYERS][i*EW+SIZE_W +: ADDR_W];
            out_size[i*SIZE_W +: SIZE_W] = stage_lanes[LAYERS][i*EW +: SIZE_W];
        end
        out_valid = stage_vld[LAYERS];
    end

    // ---------------- checks ----------------
    logic out_ascending, a_ascending, b_ascending, tail_ok;
    always_comb begin
        out_ascending = 1'b1;
        a_ascending   = 1'b1;
        b_ascending   = 1'b1;
        tail_ok       = 1'b1;
        for (int i = 0; i + 1 < ENTRIES; i++) begin
            if (out_addr[i*ADDR_W +: ADDR_W] > out_addr[(i+1)*ADDR_W +: ADDR_W])
                out_ascending = 1'b0;
            if (a_addr[i*ADDR_W +: ADDR_W] > a_addr[(i+1)*ADDR_W +: ADDR_W])
                a_ascending = 1'b0;
            if (b_addr[i*ADDR_W +: ADDR_W] > b_addr[(i+1)*ADDR_W +: ADDR_W])
                b_ascending = 1'b0;
            if ((out_addr[i*ADDR_W +: ADDR_W] == NO_PAD) &&
                (out_addr[(i+1)*ADDR_W +: ADDR_W] != NO_PAD))
                tail_ok = 1'b0;
        end
    end

    logic [$clog2(LAYERS+1)-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst < LAYERS) since_rst <= since_rst + 1'b1;
    end

    AST_IN_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (a_ascending && b_ascending)); // R6

    AST_OUT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ascending); // R2

    AST_INVALID_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> tail_ok); // R4

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= LAYERS) |-> (out_valid == $past(in_valid, LAYERS))); // R5

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < LAYERS) |-> !out_valid); // R1

endmodule

// File: tb/sorted_list_merger_bench.sv
module sorted_list_merger_bench;

    localparam int N   = 8;
    localparam int AW  = 11;
    localparam int SW  = 3;
    localparam int LAT = 4;
    localparam int NV  = 7;
    localparam int NP  = 2047;

    localparam int VA [NV][N] = '{
        '{1, 4, 8, 13, 18, 22, 27, 31},
        '{NP, NP, NP, NP, NP, NP, NP, NP},
        '{5, 9, NP, NP, NP, NP, NP, NP},
        '{NP, NP, NP, NP, NP, NP, NP, NP},
        '{0, 2, 4, 6, 8, 10, 12, 14},
        '{100, 200, 300, NP, NP, NP, NP, NP},
        '{767, NP, NP, NP, NP, NP, NP, NP}
    };
    localparam int VB [NV][N] = '{
        '{770, 771, 800, 900, 1000, 1200, 1400, 1535},
        '{768, 780, 790, 1024, 1100, 1300, 1500, 1535},
        '{800, 900, NP, NP, NP, NP, NP, NP},
        '{NP, NP, NP, NP, NP, NP, NP, NP},
        '{1, 3, 5, 7, 9, 11, 13, 15},
        '{50, 60, 70, 80, 90, NP, NP, NP},
        '{768, 769, 770, 771, 772, 773, 774, 775}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N*AW-1:0] a_addr = '1, b_addr = '1;
    logic [N*SW-1:0] a_size = '0, b_size = '0;
    logic out_valid;
    logic [N*AW-1:0] out_addr;
    logic [N*SW-1:0] out_size;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sorted_list_merger u_sorted_list_merger (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_addr(a_addr), .a_size(a_size), .b_addr(b_addr), .b_size(b_size),
        .out_valid(out_valid), .out_addr(out_addr), .out_size(out_size)
    );

    function automatic int size_of(input int adr);
        return (adr * 5 + 1) % 8;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input int v);
        for (int i = 0; i < N; i++) begin
            a_addr[i*AW +: AW] = AW'(VA[v][i]);
            b_addr[i*AW +: AW] = AW'(VB[v][i]);
            a_size[i*SW +: SW] = SW'(size_of(VA[v][i]));
            b_size[i*SW +: SW] = SW'(size_of(VB[v][i]));
        end
        in_valid = 1'b1;
    endtask

    // Reference: two-pointer merge of the sorted lists, first eight kept.
    task automatic check_result(input int v);
        int ia = 0, ib = 0;
        int exp_a [N];
        bit addr_ok = 1'b1, size_ok = 1'b1;
        int bad_act = 0, bad_exp = 0, sbad_act = 0, sbad_exp = 0;
        for (int k = 0; k < N; k++) begin
            if (VA[v][ia] <= VB[v][ib]) begin exp_a[k] = VA[v][ia]; ia++; end
            else begin exp_a[k] = VB[v][ib]; ib++; end
        end
        chk(out_valid === 1'b1, "R5", $sformatf("valid v%0d", v), int'(out_valid), 1);
        for (int k = 0; k < N; k++) begin
            int got_a, got_s;
            got_a = int'(out_addr[k*AW +: AW]);
            got_s = int'(out_size[k*SW +: SW]);
            if (got_a != exp_a[k] && addr_ok) begin
                addr_ok = 1'b0; bad_act = got_a; bad_exp = exp_a[k];
            end
            if (exp_a[k] != NP && got_s != size_of(exp_a[k]) && size_ok) begin
                size_ok = 1'b0; sbad_act = got_s; sbad_exp = size_of(exp_a[k]);
            end
        end
        // R2 ordering, R4 sentinel tail, R6 arbitrary sorted lists
        chk(addr_ok, "R2/R4/R6", $sformatf("addresses v%0d", v), bad_act, bad_exp);
        chk(size_ok, "R3", $sformatf("sizes v%0d", v), sbad_act, sbad_exp);
    endtask

    task automatic check_idle(input string req);
        bit all_np = 1'b1;
        for (int k = 0; k < N; k++)
            if (out_addr[k*AW +: AW] != AW'(NP)) all_np = 1'b0;
        chk(out_valid === 1'b0, req, "valid low", int'(out_valid), 0);
        chk(all_np, req, "slots empty", int'(out_addr[AW-1:0]), NP);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // Back-to-back stream over the vector table
        for (int c = 0; c < NV + LAT; c++) begin
            if (c >= LAT) check_result(c - LAT);
            if (c < NV) drive(c);
            else in_valid = 1'b0;
            @(negedge clk);
        end
        chk(out_valid === 1'b0, "R5", "valid drops after stream", int'(out_valid), 0);

        // Single pair: valid exactly LAT clocks later, for one cycle
        drive(4);
        @(negedge clk);
        in_valid = 1'b0;
        for (int w = 1; w < LAT; w++) begin
            chk(out_valid === 1'b0, "R5", $sformatf("early valid at %0d", w), int'(out_valid), 0);
            @(negedge clk);
        end
        check_result(4);
        @(negedge clk);
        chk(out_valid === 1'b0, "R5", "single pulse", int'(out_valid), 0);

        // Reset with the pipeline full
        for (int c = 0; c < 3; c++) begin drive(c); @(negedge clk); end
        rst_n = 1'b0;
        #1;
        check_idle("R1");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule